// File: doc/BRIEF.md
# Barrel Shifter with Carry Out

A purely combinational word shifter for shifts whose distance comes from a register rather than an instruction immediate. One 32-bit operand is moved left or right, logically or arithmetically, or rotated right. The block also produces the carry flag that such a shift leaves behind, so an integer pipeline can take the shifted value and the updated carry from the same stage.

The shift distance port is a full word, but only its low eight bits count. Distances from 32 to 255 are legal and well defined for every operation. Rotation wraps the distance modulo 32 for the data, yet still looks at all eight bits when it decides the carry. A distance of zero leaves both the operand and the incoming carry unchanged.

Internally a decoder sorts the distance into zero, in-range, exactly-word-width or beyond-width. A logarithmic stage network handles distances below the word width. A separate picker selects the carry bit. The top applies the out-of-range overrides. Operation codes on `op_i` are 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right.

Top module: `barrel_shifter_cy`

## Requirements
- R1: Bits 31..8 of `amount_i` have no effect on `result_o` or `carry_o`; only `amount_i[7:0]` (called N below) is used.
- R2: When N is 0, `result_o` equals `opnd_i` and `carry_o` equals `carry_i`, for all four operations.
- R3: Logical left (op 0) with N in 1..31 gives `opnd_i << N`, with the carry taken from operand bit 32−N.
- R4: Logical left with N of 32 gives zero with the carry from operand bit 0. With N above 32 the result is zero and the carry is 0.
- R5: Logical right (op 1) and arithmetic right (op 2) with N in 1..31 give the zero-filled or sign-filled shift, with the carry from operand bit N−1.
- R6: Logical right with N of 32 gives zero with the carry from operand bit 31. With N above 32 the result is zero and the carry is 0.
- R7: Arithmetic right with N of 32 or more gives operand bit 31 copied into every bit, and that same bit as the carry.
- R8: Rotate right (op 3) with N[4:0] nonzero rotates the operand by N[4:0], with the carry from operand bit N[4:0]−1, which is the new bit 31.
- R9: Rotate right with N nonzero but N[4:0] zero leaves the operand unchanged, with the carry from operand bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to be shifted |
| amount_i | input | 32 | Shift distance; only the low 8 bits are used |
| op_i | input | 2 | 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Outgoing carry flag |

## Verification
The embedded checks evaluate only after the combinational inputs have settled. They assume all inputs carry known values and that the operation code is one of the four defined encodings. The stimulus holds each input vector steady for a full time step before it samples the outputs. It uses only two-state values, and because every 2-bit code is defined, the sweep never leaves that envelope. The bench walks all 256 low-byte distances for every operation and both carry values, over edge-pattern and random operands, and then repeats the sweep with random upper distance bits.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [1:0] {
        SHF_LSL = 2'd0,
        SHF_LSR = 2'd1,
        SHF_ASR = 2'd2,
        SHF_ROR = 2'd3
    } shf_op_e;
endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode #(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int LOG2W   = $clog2(WIDTH)
) (
    input  logic [AMT_BITS-1:0] amt_i,
    output logic                is_zero_o,
    output logic                at_width_o,
    output logic                beyond_o,
    output logic [LOG2W-1:0]    sub_amt_o
);
    localparam logic [AMT_BITS-1:0] WIDTH_AMT = AMT_BITS'(WIDTH);

    always_comb begin
        is_zero_o  = (amt_i == '0);
        at_width_o = (amt_i == WIDTH_AMT);
        beyond_o   = (amt_i > WIDTH_AMT);
        sub_amt_o  = amt_i[LOG2W-1:0];
    end
endmodule

// File: rtl/shf_stage_net.sv
module shf_stage_net
    import shf_pkg::*;
#(
    parameter int WIDTH  = 32,
    localparam int LOG2W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  shf_op_e          op_i,
    input  logic [LOG2W-1:0] sub_amt_i,
    output logic [WIDTH-1:0] moved_o
);
    logic [WIDTH-1:0] lvl [LOG2W+1];
    logic             sign_bit;

    assign sign_bit = opnd_i[WIDTH-1];
    assign lvl[0]   = opnd_i;

    for (genvar k = 0; k < LOG2W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [WIDTH-1:0] step_val;
        always_comb begin
            unique case (op_i)
                SHF_LSL: step_val = {lvl[k][WIDTH-1-STEP:0], {STEP{1'b0}}};
                SHF_LSR: step_val = {{STEP{1'b0}}, lvl[k][WIDTH-1:STEP]};
                SHF_ASR: step_val = {{STEP{sign_bit}}, lvl[k][WIDTH-1:STEP]};
                SHF_ROR: step_val = {lvl[k][STEP-1:0], lvl[k][WIDTH-1:STEP]};
                default: step_val = lvl[k];
            endcase
        end
        assign lvl[k+1] = sub_amt_i[k] ? step_val : lvl[k];
    end

    assign moved_o = lvl[LOG2W];
endmodule

// File: rtl/shf_carry_pick.sv
module shf_carry_pick
    import shf_pkg::*;
#(
    parameter int WIDTH  = 32,
    localparam int LOG2W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  shf_op_e          op_i,
    input  logic             is_zero_i,
    input  logic             at_width_i,
    input  logic             beyond_i,
    input  logic [LOG2W-1:0] sub_amt_i,
    input  logic             carry_i,
    output logic             carry_o
);
    logic [LOG2W-1:0] idx_left;
    logic [LOG2W-1:0] idx_right;

    assign idx_left  = LOG2W'(0) - sub_amt_i;
    assign idx_right = sub_amt_i - LOG2W'(1);

    always_comb begin
        if (is_zero_i) begin
            carry_o = carry_i;
        end else begin
            unique case (op_i)
                SHF_LSL: carry_o = beyond_i ? 1'b0 :
                                   at_width_i ? opnd_i[0] : opnd_i[idx_left];
                SHF_LSR: carry_o = beyond_i ? 1'b0 :
                                   at_width_i ? opnd_i[WIDTH-1] : opnd_i[idx_right];
                SHF_ASR: carry_o = (beyond_i || at_width_i) ? opnd_i[WIDTH-1]
                                                            : opnd_i[idx_right];
                SHF_ROR: carry_o = opnd_i[idx_right];
                default: carry_o = carry_i;
            endcase
        end
    end
endmodule

// File: rtl/barrel_shifter_cy.sv
module barrel_shifter_cy
    import shf_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_IN_W = 32,
    parameter int AMT_BITS = 8,
    localparam int LOG2W   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]    opnd_i,
    input  logic [AMT_IN_W-1:0] amount_i,
    input  logic [1:0]          op_i,
    input  logic                carry_i,
    output logic [WIDTH-1:0]    result_o,
    output logic                carry_o
);
    shf_op_e          op_sel;
    logic             is_zero, at_width, beyond;
    logic [LOG2W-1:0] sub_amt;
    logic [WIDTH-1:0] net_val;

    assign op_sel = shf_op_e'(op_i);

    shf_amount_decode #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_dec (
        .amt_i      (amount_i[AMT_BITS-1:0]),
        .is_zero_o  (is_zero),
        .at_width_o (at_width),
        .beyond_o   (beyond),
        .sub_amt_o  (sub_amt)
    );

    shf_stage_net #(.WIDTH(WIDTH)) u_net (
        .opnd_i    (opnd_i),
        .op_i      (op_sel),
        .sub_amt_i (sub_amt),
        .moved_o   (net_val)
    );

    shf_carry_pick #(.WIDTH(WIDTH)) u_cy (
        .opnd_i     (opnd_i),
        .op_i       (op_sel),
        .is_zero_i  (is_zero),
        .at_width_i (at_width),
        .beyond_i   (beyond),
        .sub_amt_i  (sub_amt),
        .carry_i    (carry_i),
        .carry_o    (carry_o)
    );

    always_comb begin
        if (is_zero) begin
            result_o = opnd_i;
        end else begin
            unique case (op_sel)
                SHF_LSL, SHF_LSR: result_o = (at_width || beyond) ? '0 : net_val;
                SHF_ASR:          result_o = (at_width || beyond) ? {WIDTH{opnd_i[WIDTH-1]}}
                                                                  : net_val;
                SHF_ROR:          result_o = net_val;
                default:          result_o = net_val;
            endcase
        end
    end

    always_comb begin
        if (amount_i[AMT_BITS-1:0] == '0) begin
            AST_ZERO_PASS: assert (result_o == opnd_i && carry_o == carry_i); // R2
        end
        if (op_i == 2'd0 && amount_i[AMT_BITS-1:0] > AMT_BITS'(WIDTH)) begin
            AST_LSL_CLEAR: assert (result_o == '0 && carry_o == 1'b0); // R4
        end
        if (op_i == 2'd1 && amount_i[AMT_BITS-1:0] > AMT_BITS'(WIDTH)) begin
            AST_LSR_CLEAR: assert (result_o == '0 && carry_o == 1'b0); // R6
        end
        if (op_i == 2'd2 && amount_i[AMT_BITS-1:0] >= AMT_BITS'(WIDTH)) begin
            AST_ASR_FILL: assert (carry_o == opnd_i[WIDTH-1] &&
                                  $countones(result_o) == (opnd_i[WIDTH-1] ? WIDTH : 0)); // R7
        end
        if (op_i == 2'd3 && amount_i[AMT_BITS-1:0] != '0 && amount_i[LOG2W-1:0] == '0) begin
            AST_ROR_WRAP: assert (result_o == opnd_i && carry_o == opnd_i[WIDTH-1]); // R9
        end
        if (op_i == 2'd3 && amount_i[AMT_BITS-1:0] != '0) begin
            AST_ROR_CARRY: assert (carry_o == result_o[WIDTH-1]); // R8
        end
    end
endmodule

// File: tb/tb_barrel_shifter_cy.sv
module tb_barrel_shifter_cy;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic [31:0] opnd;
    logic [31:0] amount;
    logic [1:0]  op;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_shifter_cy dut (
        .opnd_i   (opnd),
        .amount_i (amount),
        .op_i     (op),
        .carry_i  (cin),
        .result_o (result),
        .carry_o  (cout)
    );

    task automatic run_vec(input logic [31:0] x, input logic [31:0] amt,
                           input logic [1:0] o, input logic c, input string tag_in);
        logic [63:0] wide;
        logic [31:0] exp_r;
        logic        exp_c;
        int          n;
        int          r;
        string       tag;
        n = int'(amt[7:0]);
        if (n == 0) begin
            exp_r = x; exp_c = c; tag = "R2";
        end else begin
            case (o)
                2'd0: begin
                    wide  = {32'h0, x} << n;
                    exp_r = wide[31:0]; exp_c = wide[32];
                    tag   = (n < 32) ? "R3" : "R4";
                end
                2'd1: begin
                    wide  = {x, 32'h0} >> n;
                    exp_r = wide[63:32]; exp_c = wide[31];
                    tag   = (n < 32) ? "R5" : "R6";
                end
                2'd2: begin
                    wide  = 64'($signed({x, 32'h0}) >>> n);
                    exp_r = wide[63:32]; exp_c = wide[31];
                    tag   = (n < 32) ? "R5" : "R7";
                end
                default: begin
                    r     = n % 32;
                    exp_r = (r == 0) ? x : ((x >> r) | (x << (32 - r)));
                    exp_c = exp_r[31];
                    tag   = (r != 0) ? "R8" : "R9";
                end
            endcase
        end
        if (tag_in != "") tag = tag_in;
        opnd = x; amount = amt; op = o; cin = c;
        #1;
        n_checks++;
        if (result !== exp_r || cout !== exp_c) begin
            n_fail++;
            $display("FAIL %s op=%0d n=%0d x=%08h: got res=%08h c=%0b, expected res=%08h c=%0b",
                     tag, o, n, x, result, cout, exp_r, exp_c);
        end
        #1;
    endtask

    initial begin
        logic [31:0] pats [8];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
        pats[4] = 32'hA5A5_5A5A; pats[5] = $urandom;
        pats[6] = $urandom;      pats[7] = $urandom;
        opnd = '0; amount = '0; op = '0; cin = 1'b0;
        #3;
        // zero-distance idle state, both carry values: R2
        run_vec(32'h1234_5678, 32'h0, 2'd0, 1'b1, "R2");
        run_vec(32'h1234_5678, 32'h0, 2'd3, 1'b0, "R2");
        for (int p = 0; p < 8; p++)
            for (int o = 0; o < 4; o++)
                for (int c = 0; c < 2; c++)
                    for (int a = 0; a < 256; a++)
                        run_vec(pats[p], 32'(a), 2'(o), 1'(c), "");
        // upper distance bits must be ignored: R1
        for (int o = 0; o < 4; o++)
            for (int a = 0; a < 256; a++)
                run_vec($urandom, {$urandom_range(1, 32'hFF_FFFF), 8'(a)} & 32'hFFFF_FFFF,
                        2'(o), 1'($urandom_range(0, 1)), "R1");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule